// File: doc/BRIEF.md
# I2C Register-Access Target

This block sits on a two-wire I2C bus as a target device and opens a 128-byte register space to the bus controller. It watches SCL and SDA through a synchronizer clocked by a system clock that runs at least eight times the SCL rate. It recognizes START, repeated START and STOP conditions and answers to a 7-bit device address. The upper six bits of that address are a parameter, and the lowest bit is taken from a strap input.

After a matching address with the write direction, the controller sends one pointer byte. Bits [6:0] of that byte pick a register, and bit 7 asks for the pointer to step forward after every data byte. Data bytes that follow are acknowledged and written through a simple register-file port. To read, the controller sets the pointer, issues a repeated START and then the address with the read direction. The block then shifts register bytes out MSB first until the controller answers a byte with NACK. The register file itself is outside the block: it returns read data combinationally for the address the block presents.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is held, the block does not pull SDA (`sda_pull_o` = 0) and raises neither `reg_we_o` nor `reg_re_o`.
- R2: An address byte whose upper seven bits equal {110101b, `addr_lsb_i`} is acknowledged. The block pulls SDA low in the ninth clock, so device 1101010b answers with the strap low and 1101011b with the strap high. Bit 0 of the byte selects the direction, 1 = read and 0 = write.
- R3: An address byte that does not match gets no ACK. The block then ignores all bytes, produces no write or read strobe and never pulls SDA until the next START.
- R4: The block changes its SDA drive only while SCL is low. Its ACK stays low for the whole high phase of the ninth SCL pulse.
- R5: In a write, the byte after the address is the pointer byte, and each later byte is acknowledged. Each later byte also produces one `reg_we_o` pulse with `reg_wdata_o` equal to the byte and `reg_addr_o` equal to the current pointer (initially pointer byte bits [6:0]).
- R6: With pointer-byte bit 7 = 0, every data byte of the transfer, read or written, uses the same register address. With bit 7 = 1, the address rises by one after every byte.
- R7: An auto-incrementing pointer wraps from 127 to 0.
- R8: In a read, each byte comes from `reg_rdata_i` at the current pointer and is sent MSB first. One `reg_re_o` pulse marks each byte fetched, with `reg_addr_o` holding its address.
- R9: A NACK from the controller after a read byte ends the transmission. SDA stays released and no further byte is fetched until a new START.
- R10: `reg_we_o` and `reg_re_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_lsb_i | input | 1 | Strap giving the device address LSB |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_addr_o | output | 7 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| reg_re_o | output | 1 | Read strobe, one cycle |

## Verification
The bench drives both strap levels and also sends the address for the opposite strap. A design that compares against a fixed low bit would acknowledge the wrong device or write registers it was never asked to touch. Bursts cross the 127-to-0 boundary in both directions, so a pointer that saturates or carries into an eighth bit shows up as a misplaced write or a wrong read byte. Reads with pointer-byte bit 7 clear must return the same register twice. The last read byte is answered with NACK: a design that keeps going would fetch another register and hold SDA against the STOP. The ACK level is sampled at both ends of the high phase, which catches a release that comes one edge too early.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [5:0] DEV_ID_HI   = 6'b110101,
  parameter int         SYNC_STAGES = 2,
  parameter int         REG_AW      = 7,
  parameter int         DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_lsb_i,
  output logic              sda_pull_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_re_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } state_t;

  state_t             st;
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic               scl_q, sda_q, scl_s, sda_s;
  logic               scl_rise, scl_fall, start_c, stop_c;
  logic [DATA_W-1:0]  shreg;
  logic [CNT_W-1:0]   cnt;
  logic [REG_AW-1:0]  ptr;
  logic               rd_mode, auto_inc, ctl_ack;

  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_s      = sda_sync[SYNC_STAGES-1];
  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_c    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c     = scl_s & scl_q & ~sda_q & sda_s;
  assign reg_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      shreg       <= '0;
      cnt         <= '0;
      ptr         <= '0;
      rd_mode     <= 1'b0;
      auto_inc    <= 1'b0;
      ctl_ack     <= 1'b0;
      sda_pull_o  <= 1'b0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (start_c) begin
        st         <= S_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_PTR, S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (shreg[7:1] == {DEV_ID_HI, addr_lsb_i}) begin
                  sda_pull_o <= 1'b1;
                  rd_mode    <= shreg[0];
                  st         <= S_ADDR_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_PTR) begin
                ptr        <= shreg[REG_AW-1:0];
                auto_inc   <= shreg[DATA_W-1];
                sda_pull_o <= 1'b1;
                st         <= S_PTR_ACK;
              end else begin
                reg_wdata_o <= shreg;
                reg_we_o    <= 1'b1;
                sda_pull_o  <= 1'b1;
                st          <= S_WR_ACK;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                shreg      <= reg_rdata_i;
                sda_pull_o <= ~reg_rdata_i[DATA_W-1];
                reg_re_o   <= 1'b1;
                st         <= S_RD;
              end else begin
                sda_pull_o <= 1'b0;
                st         <= S_PTR;
              end
            end
          end
          S_PTR_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              st         <= S_WR;
            end
          end
          S_WR_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              if (auto_inc) ptr <= ptr + 1'b1;
              st <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                cnt        <= '0;
                sda_pull_o <= 1'b0;
                st         <= S_RD_ACK;
              end else begin
                shreg      <= {shreg[DATA_W-2:0], 1'b0};
                sda_pull_o <= ~shreg[DATA_W-2];
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              ctl_ack <= ~sda_s;
              if (~sda_s && auto_inc) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (ctl_ack) begin
                shreg      <= reg_rdata_i;
                sda_pull_o <= ~reg_rdata_i[DATA_W-1];
                reg_re_o   <= 1'b1;
                st         <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);
  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
  // R10
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);
  // R10
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));
  // R5
  we_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_we_o) |-> !scl_i);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_pull, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic scl, sda;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [14:0] wq[$];
  logic [6:0] rq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  assign scl = scl_m;
  assign sda = sda_m & ~sda_pull;
  assign reg_rdata = mem[reg_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .addr_lsb_i(strap),
    .sda_pull_o(sda_pull), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata), .reg_re_o(reg_re)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (reg_we) begin
      if (wq.size() == 0) check(0, "R3", "unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [14:0] e;
        e = wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R5", "write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_re) begin
      if (rq.size() == 0) check(0, "R9", "unexpected read strobe", reg_addr, 0);
      else begin
        logic [6:0] a;
        a = rq.pop_front();
        check(reg_addr == a, "R8", "read strobe addr", reg_addr, a);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      cyc(HP/2); sda_m = 1'b1; cyc(HP/2); scl_m = 1'b1; cyc(HP);
    end else begin
      sda_m = 1'b1; cyc(HP);
    end
    sda_m = 1'b0; cyc(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    cyc(HP/2); sda_m = 1'b0; cyc(HP/2); scl_m = 1'b1; cyc(HP);
    sda_m = 1'b1; cyc(HP);
  endtask

  task automatic put_bit(input bit b);
    cyc(HP/2); sda_m = b; cyc(HP/2); scl_m = 1'b1; cyc(HP); scl_m = 1'b0;
  endtask

  task automatic get_bit(output bit b, output bit held);
    bit s1;
    cyc(HP/2); sda_m = 1'b1; cyc(HP/2); scl_m = 1'b1;
    cyc(1); s1 = sda; cyc(HP-2); b = sda; held = (s1 == b); cyc(1); scl_m = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, input bit exp_ack, input string req);
    bit b, held;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b, held);
    check((!b && held) == exp_ack, req, "ACK on byte", !b && held, exp_ack);
  endtask

  task automatic recv(input logic [6:0] a, input bit nack);
    logic [7:0] v;
    bit b, held;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, held);
      v[i] = b;
    end
    put_bit(nack);
    check(v == exp_mem[a], "R8", "read byte", v, exp_mem[a]);
  endtask

  task automatic push_wr(input logic [6:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    exp_mem[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    cyc(3);
    check(sda_pull == 0 && reg_we == 0 && reg_re == 0, "R1", "outputs in reset",
          {sda_pull, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    cyc(10);

    // R2 strap low, R5 write, R6 no increment
    strap = 1'b0;
    bus_start();
    send(8'hD4, 1, "R2");
    send(8'h05, 1, "R5");
    push_wr(7'h05, 8'hA1);
    send(8'hA1, 1, "R5");
    push_wr(7'h05, 8'hB2);
    send(8'hB2, 1, "R6");
    bus_stop();

    // R2 strap high, R7 wrap on write
    strap = 1'b1;
    bus_start();
    send(8'hD6, 1, "R2");
    send(8'hFE, 1, "R5");
    push_wr(7'h7E, 8'h11); send(8'h11, 1, "R6");
    push_wr(7'h7F, 8'h22); send(8'h22, 1, "R6");
    push_wr(7'h00, 8'h33); send(8'h33, 1, "R7");
    bus_stop();

    // R3 mismatch: strap high but address LSB 0
    bus_start();
    send(8'hD4, 0, "R3");
    send(8'h10, 0, "R3");
    send(8'h99, 0, "R3");
    bus_stop();
    check(mem[7'h10] == exp_mem[7'h10], "R3", "untouched register", mem[7'h10], exp_mem[7'h10]);

    // R8 read with increment and wrap, R9 NACK end
    bus_start();
    send(8'hD6, 1, "R2");
    send(8'hFF, 1, "R8");
    bus_start();
    rq.push_back(7'h7F); rq.push_back(7'h00); rq.push_back(7'h01);
    send(8'hD7, 1, "R8");
    recv(7'h7F, 0);
    recv(7'h00, 0);
    recv(7'h01, 1);
    cyc(4);
    check(sda_pull == 0, "R9", "SDA released after NACK", sda_pull, 0);
    cyc(HP*3);
    check(sda_pull == 0 && rq.size() == 0, "R9", "no fetch after NACK", rq.size(), 0);
    bus_stop();

    // R6 read without increment
    bus_start();
    send(8'hD6, 1, "R2");
    send(8'h05, 1, "R6");
    bus_start();
    rq.push_back(7'h05); rq.push_back(7'h05);
    send(8'hD7, 1, "R8");
    recv(7'h05, 0);
    recv(7'h05, 1);
    bus_stop();

    cyc(20);
    check(wq.size() == 0, "R5", "pending writes", wq.size(), 0);
    check(rq.size() == 0, "R8", "pending reads", rq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule